// File: doc/BRIEF.md
# Deferred Event Mode Selector

This block chooses the delivery path for platform general-purpose events. In legacy mode the events go out on the legacy path. In exposed mode they are routed out as GPIO-style interrupt lines instead. A mode choice never changes during a running boot. Software running in a boot may announce that it can handle exposed delivery, and that announcement decides the mode used after the next boot pulse.

The announcement has to be made again on every boot. If a boot ends without it, the next boot is armed for legacy mode. Leaving exposed mode therefore takes two boot pulses. The first pulse is where the missing announcement is noticed and legacy is armed. The second pulse applies legacy.

A cold power-up reset (`por_n` low) clears everything and selects legacy. The warm boot pulse `boot_pulse` commits the armed mode on its rising edge.

Top module: `event_mode_sel`

## Requirements
- R1: While `por_n` is low, and after it is released, `mode_active`, `mode_pending` and `status` are all zero, which means legacy is both active and armed.
- R2: A valid support request (`req_valid` high with `boot_pulse` low) sets `mode_pending` to 1 in the following cycle and leaves `mode_active` unchanged. A request is valid when `req_rev`=1, `req_fn`=1 and `req_val`=1.
- R3: On the clock where `boot_pulse` is high and was low in the previous cycle, `mode_active` takes the value `mode_pending` had. In the same cycle the signal-seen flag and `mode_pending` clear to 0.
- R4: `mode_active` changes only at a boot-pulse rising edge or at cold reset. It holds for the whole boot epoch.
- R5: A request with any other revision, function index or value has no effect on `mode_pending`.
- R6: After the first valid request in a boot, further valid requests in the same boot have no additional effect, and `mode_pending` stays 1.
- R7: If a boot ends without a valid request, the next boot pulse applies legacy. Going from active exposed to active legacy takes two boot pulses.
- R8: With `mode_active`=0, `legacy_evt` equals `evt_in` and `gpio_evt` is zero. With `mode_active`=1, `gpio_evt` equals `evt_in` and `legacy_evt` is zero. An event never appears on both paths.
- R9: Requests made while `boot_pulse` is high are ignored. Holding `boot_pulse` high for several cycles commits only once.
- R10: `status` bit 0 is the active mode, bit 1 is the pending mode and bit 2 is the signal-seen flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Cold power-up reset, active low, asynchronous |
| boot_pulse | input | 1 | Warm boot pulse; rising edge commits the armed mode |
| req_valid | input | 1 | Software support request strobe |
| req_rev | input | REQ_W | Request revision |
| req_fn | input | REQ_W | Request function index |
| req_val | input | REQ_W | Request value |
| evt_in | input | NEVT | Incoming platform events |
| mode_active | output | 1 | Active mode, 1 = exposed |
| mode_pending | output | 1 | Mode armed for the next boot |
| status | output | 3 | Read-only status {seen, pending, active} |
| legacy_evt | output | NEVT | Events on the legacy path |
| gpio_evt | output | NEVT | Events on the interrupt-line path |

## Verification
The bench walks the full fallback from exposed to legacy. A design that applied the missing announcement in one reset would drop to legacy one boot too early. It holds the boot pulse high for several cycles and strobes during it. A level-sensitive commit, or one that accepts requests while the pulse is high, would leave the wrong mode armed. It sends requests with each of revision, function index and value wrong one at a time, so a decoder that checks only some of the fields would arm exposed mode. It also checks the event routing in both modes, which catches a swapped or leaking path.

// File: rtl/event_mode_sel.sv
module event_mode_sel #(
  parameter int NEVT   = 8,
  parameter int REQ_W  = 8,
  parameter int REV_OK = 1,
  parameter int FN_OK  = 1,
  parameter int VAL_OK = 1
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             boot_pulse,
  input  logic             req_valid,
  input  logic [REQ_W-1:0] req_rev,
  input  logic [REQ_W-1:0] req_fn,
  input  logic [REQ_W-1:0] req_val,
  input  logic [NEVT-1:0]  evt_in,
  output logic             mode_active,
  output logic             mode_pending,
  output logic [2:0]       status,
  output logic [NEVT-1:0]  legacy_evt,
  output logic [NEVT-1:0]  gpio_evt
);
  localparam logic [REQ_W-1:0] K_REV = REQ_W'(REV_OK);
  localparam logic [REQ_W-1:0] K_FN  = REQ_W'(FN_OK);
  localparam logic [REQ_W-1:0] K_VAL = REQ_W'(VAL_OK);

  logic boot_q, act_q, seen_q;

  wire boot_edge = boot_pulse & ~boot_q;
  wire fields_ok = (req_rev == K_REV) && (req_fn == K_FN) && (req_val == K_VAL);
  wire req_ok    = req_valid & ~boot_pulse & fields_ok;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      boot_q <= 1'b0;
      act_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      boot_q <= boot_pulse;
      if (boot_edge) begin
        act_q  <= seen_q;
        seen_q <= 1'b0;
      end else if (req_ok) begin
        seen_q <= 1'b1;
      end
    end
  end

  assign mode_active  = act_q;
  assign mode_pending = seen_q;
  assign status       = {seen_q, seen_q, act_q};
  assign legacy_evt   = act_q ? '0 : evt_in;
  assign gpio_evt     = act_q ? evt_in : '0;
endmodule

module event_mode_sel_chk #(
  parameter int NEVT   = 8,
  parameter int REQ_W  = 8,
  parameter int REV_OK = 1,
  parameter int FN_OK  = 1,
  parameter int VAL_OK = 1
) (
  input logic             clk,
  input logic             por_n,
  input logic             boot_pulse,
  input logic             req_valid,
  input logic [REQ_W-1:0] req_rev,
  input logic [REQ_W-1:0] req_fn,
  input logic [REQ_W-1:0] req_val,
  input logic [NEVT-1:0]  evt_in,
  input logic             mode_active,
  input logic             mode_pending,
  input logic [NEVT-1:0]  legacy_evt,
  input logic [NEVT-1:0]  gpio_evt
);
  logic boot_prev;
  always_ff @(posedge clk or negedge por_n)
    if (!por_n) boot_prev <= 1'b0;
    else        boot_prev <= boot_pulse;

  wire edge_now = boot_pulse & ~boot_prev;
  wire good_req = req_valid && (req_rev == REQ_W'(REV_OK)) &&
                  (req_fn == REQ_W'(FN_OK)) && (req_val == REQ_W'(VAL_OK));

  AST_COLD_LEGACY: assert property (@(posedge clk) !por_n |-> (!mode_active && !mode_pending)); // R1
  AST_REQ_ARMS: assert property (@(posedge clk) disable iff (!por_n)
    (good_req && !boot_pulse) |=> mode_pending); // R2
  AST_COMMIT: assert property (@(posedge clk) disable iff (!por_n)
    edge_now |=> (mode_active == $past(mode_pending)) && !mode_pending); // R3
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    !edge_now |=> $stable(mode_active)); // R4
  AST_BAD_REQ: assert property (@(posedge clk) disable iff (!por_n)
    (!edge_now && !good_req) |=> $stable(mode_pending)); // R5
  AST_HIGH_IGNORED: assert property (@(posedge clk) disable iff (!por_n)
    (boot_pulse && boot_prev) |=> $stable(mode_pending) && $stable(mode_active)); // R9
  AST_ROUTE_SPLIT: assert property (@(posedge clk) disable iff (!por_n)
    ((legacy_evt & gpio_evt) == '0) && ((legacy_evt | gpio_evt) == evt_in)); // R8
endmodule

bind event_mode_sel event_mode_sel_chk #(
  .NEVT(NEVT), .REQ_W(REQ_W), .REV_OK(REV_OK), .FN_OK(FN_OK), .VAL_OK(VAL_OK)
) u_chk (
  .clk(clk), .por_n(por_n), .boot_pulse(boot_pulse), .req_valid(req_valid),
  .req_rev(req_rev), .req_fn(req_fn), .req_val(req_val), .evt_in(evt_in),
  .mode_active(mode_active), .mode_pending(mode_pending),
  .legacy_evt(legacy_evt), .gpio_evt(gpio_evt)
);

// File: tb/event_mode_sel_bench.sv
module event_mode_sel_bench;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       boot_pulse = 1'b0;
  logic       req_valid = 1'b0;
  logic [7:0] req_rev = 8'd0, req_fn = 8'd0, req_val = 8'd0;
  logic [7:0] evt_in = 8'd0;
  logic       mode_active, mode_pending;
  logic [2:0] status;
  logic [7:0] legacy_evt, gpio_evt;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  event_mode_sel u_event_mode_sel (
    .clk(clk), .por_n(por_n), .boot_pulse(boot_pulse), .req_valid(req_valid),
    .req_rev(req_rev), .req_fn(req_fn), .req_val(req_val), .evt_in(evt_in),
    .mode_active(mode_active), .mode_pending(mode_pending), .status(status),
    .legacy_evt(legacy_evt), .gpio_evt(gpio_evt)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_req(input logic [7:0] rv, input logic [7:0] fn, input logic [7:0] vl);
    @(negedge clk);
    req_valid = 1'b1; req_rev = rv; req_fn = fn; req_val = vl;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic boot(input int cycles);
    @(negedge clk);
    boot_pulse = 1'b1;
    repeat (cycles) @(negedge clk);
    boot_pulse = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check("R1 active", 16'(mode_active), 16'd0);
    check("R1 status", 16'(status), 16'd0);
    @(negedge clk); por_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 16'(status), 16'd0);
  endtask

  task automatic t_request();
    send_req(8'd1, 8'd1, 8'd1);
    check("R2 pending set", 16'(mode_pending), 16'd1);
    check("R2 active unchanged", 16'(mode_active), 16'd0);
    check("R10 status pending+seen", 16'(status), 16'b110);
  endtask

  task automatic t_boot_held();
    @(negedge clk);
    boot_pulse = 1'b1;
    @(negedge clk);
    check("R3 commit exposed", 16'(mode_active), 16'd1);
    check("R3 pending cleared", 16'(mode_pending), 16'd0);
    req_valid = 1'b1; req_rev = 8'd1; req_fn = 8'd1; req_val = 8'd1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    check("R9 req during pulse ignored", 16'(mode_pending), 16'd0);
    check("R9 single commit", 16'(mode_active), 16'd1);
    boot_pulse = 1'b0;
    @(negedge clk);
    check("R10 status active only", 16'(status), 16'b001);
  endtask

  task automatic t_routing(input logic [7:0] ev, input logic exposed);
    evt_in = ev;
    #1;
    check("R8 gpio path", 16'(gpio_evt), exposed ? 16'(ev) : 16'd0);
    check("R8 legacy path", 16'(legacy_evt), exposed ? 16'd0 : 16'(ev));
  endtask

  task automatic t_bad_reqs();
    send_req(8'd2, 8'd1, 8'd1);
    check("R5 bad revision", 16'(mode_pending), 16'd0);
    send_req(8'd1, 8'd2, 8'd1);
    check("R5 bad function", 16'(mode_pending), 16'd0);
    send_req(8'd1, 8'd1, 8'd0);
    check("R5 value zero", 16'(mode_pending), 16'd0);
    send_req(8'd1, 8'd1, 8'd2);
    check("R5 value two", 16'(mode_pending), 16'd0);
  endtask

  task automatic t_repeat();
    send_req(8'd1, 8'd1, 8'd1);
    send_req(8'd1, 8'd1, 8'd1);
    check("R6 repeated request", 16'(status), 16'b111);
  endtask

  task automatic t_fallback();
    boot(1);
    check("R7 still exposed", 16'(mode_active), 16'd1);
    check("R7 pending legacy", 16'(mode_pending), 16'd0);
    t_routing(8'h3C, 1'b1);
    boot(1);
    check("R7 legacy after second boot", 16'(mode_active), 16'd0);
    t_routing(8'hA5, 1'b0);
  endtask

  task automatic t_cold();
    send_req(8'd1, 8'd1, 8'd1);
    boot(1);
    check("R3 exposed again", 16'(mode_active), 16'd1);
    send_req(8'd1, 8'd1, 8'd1);
    @(negedge clk); por_n = 1'b0;
    #1;
    check("R1 cold clears", 16'(status), 16'd0);
    @(negedge clk); por_n = 1'b1;
    @(negedge clk);
    check("R4 stays legacy", 16'(mode_active), 16'd0);
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    t_reset();
    t_routing(8'h5A, 1'b0);
    t_request();
    t_boot_held();
    t_routing(8'hA5, 1'b1);
    t_bad_reqs();
    t_repeat();
    t_fallback();
    t_cold();
    done = 1;
    finish_up();
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_up();
    end
  end
endmodule